// File: doc/BRIEF.md
# Two-Subtree Oblivious Memory Host Sequencer

This block sits on the host side of an oblivious memory store whose tree is split into two subtrees, each managed by its own secure memory module. It accepts one logical block request at a time (read or write), looks up the leaf the block currently lives under, and sends an access command to the module that owns that leaf. Write data travels with the access command.

After the access command, the sequencer polls the owning module with probe commands until the module reports that it has finished the path access. It then fetches the block and draws a fresh leaf from a free-running pseudo-random generator. It records that leaf in its position map and broadcasts an append command to both modules so the block can move under its new leaf. That leaf may be in the other subtree.

A read ends with a one-cycle response that carries the address and the fetched data. A probe that stays busy too long makes the sequencer give up on the request and raise a sticky error flag. Commands leave on a single valid/ready bus with a destination mask. Replies come back on one shared reply channel that carries the index of the module that sent them.

Top module: `oram_host_seq`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid, rsp_valid and probe_err are 0.
- R2: The first command after a request is accepted is ACCESS (cmd_op 0). It carries the request address, the write flag, the write data and the block's current leaf. It goes to the owning module only: cmd_dest 2'b01 when the leaf's top bit is 0, and 2'b10 when that bit is 1. An address never mapped since reset has leaf 0.
- R3: After ACCESS, PROBE commands (cmd_op 1) go to the same module. When a busy reply (mrsp_busy 1) is taken at clock edge t, the next PROBE is valid from edge t+4.
- R4: If the 64th PROBE of a request also gets a busy reply, probe_err goes to 1 and stays at 1 until reset. The request is dropped with no FETCH, req_ready returns to 1, and the block's position map entry is left unchanged.
- R5: A non-busy probe reply is followed by exactly one FETCH (cmd_op 2) to the owning module.
- R6: The new leaf is the low LEAF_W bits of a 16-bit LFSR, sampled at acceptance. The LFSR shifts left with bit 0 fed by s[15]^s[13]^s[12]^s[10]. It is seeded with 16'hACE1 at reset and advances once for every accepted request.
- R7: After the fetch reply, APPEND (cmd_op 3) is sent with cmd_dest 2'b11. It carries the new leaf, the address and the fetched data.
- R8: req_ready is 0 from acceptance until both modules have acknowledged APPEND (one reply each, with mrsp_src 0 and 1, in either order). It is 1 again in the cycle after the second acknowledgement, and no command is valid while it is 1.
- R9: A read completes with a single-cycle rsp_valid that carries the address and the fetched data, in the same cycle that req_ready returns to 1. A write produces no rsp_valid.
- R10: Once a request completes, the position map holds its new leaf, and the next request to that address uses that leaf.
- R11: While cmd_valid is 1 and cmd_ready is 0, the command and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Logical block address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read result pulse |
| rsp_addr | output | AW | Address of the read result |
| rsp_rdata | output | DW | Fetched block data |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken |
| cmd_op | output | 2 | 0 access, 1 probe, 2 fetch, 3 append |
| cmd_dest | output | 2 | Module mask; bit i selects module i |
| cmd_write | output | 1 | Write flag of the request |
| cmd_addr | output | AW | Block address |
| cmd_leaf | output | LW | Current leaf (access/probe/fetch) or new leaf (append) |
| cmd_data | output | DW | Write data (access) or block data (append) |
| mrsp_valid | input | 1 | Module reply present |
| mrsp_src | input | 1 | Index of replying module |
| mrsp_busy | input | 1 | Probe reply: access not finished |
| mrsp_data | input | DW | Fetch reply data |
| probe_err | output | 1 | Sticky probe timeout flag |

## Verification
The main flow is tried with a table of requests that mix writes and reads, repeat addresses, use an address that was never written, and give different numbers of busy probe replies with and without command backpressure.

- Repeated addresses show whether the position map is written back, because the second visit must target the leaf drawn on the first.
- The never-written address checks the leaf-0 default.
- Different busy counts separate a correct 4-cycle re-probe gap and probe count from an off-by-one.
- Backpressure exposes a command that changes while it is stalled.

Directed cases then drive a module that never finishes, to reach the timeout path, and apply a mid-run reset that must reseed the generator and clear the map.

// File: rtl/oram_host_seq.sv
module oram_host_seq #(
  parameter int AW        = 4,
  parameter int DW        = 32,
  parameter int LW        = 8,
  parameter int GAP       = 4,
  parameter int PROBE_MAX = 64,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [1:0]    cmd_dest,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_leaf,
  output logic [DW-1:0] cmd_data,
  input  logic          mrsp_valid,
  input  logic          mrsp_src,
  input  logic          mrsp_busy,
  input  logic [DW-1:0] mrsp_data,
  output logic          probe_err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PROBE_MAX + 1);
  localparam int GW    = $clog2(GAP + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ACC, S_PRB, S_PWT, S_GAP, S_FET, S_FWT, S_APP, S_AWT
  } state_t;

  state_t            st;
  logic [15:0]       lfsr;
  logic              wr_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     blk_q;
  logic [LW-1:0]     new_leaf;
  logic [LW-1:0]     map_q;
  logic              hit_q;
  logic [DEPTH-1:0]  map_vld;
  logic [LW-1:0]     map_mem [DEPTH];
  logic [CW-1:0]     probes;
  logic [GW-1:0]     gap_cnt;
  logic [1:0]        ack;
  logic              rsp_valid_q;

  wire [15:0]   lfsr_nxt   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  wire [LW-1:0] cur_leaf   = hit_q ? map_q : '0;
  wire          owner      = cur_leaf[LW-1];
  wire [1:0]    own_mask   = owner ? 2'b10 : 2'b01;
  wire [1:0]    src_bit    = mrsp_src ? 2'b10 : 2'b01;
  wire          from_owner = mrsp_valid && (mrsp_src == owner);
  wire          accept     = req_valid && req_ready;

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = (st == S_ACC) || (st == S_PRB) || (st == S_FET) || (st == S_APP);
  assign cmd_dest  = (st == S_APP) ? 2'b11 : own_mask;
  assign cmd_leaf  = (st == S_APP) ? new_leaf : cur_leaf;
  assign cmd_data  = (st == S_APP) ? blk_q : wdata_q;
  assign cmd_write = wr_q;
  assign cmd_addr  = addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_addr  = addr_q;
  assign rsp_rdata = blk_q;

  always_comb begin
    case (st)
      S_PRB:   cmd_op = 2'd1;
      S_FET:   cmd_op = 2'd2;
      S_APP:   cmd_op = 2'd3;
      default: cmd_op = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (accept) map_q <= map_mem[req_addr];
    if (st == S_FWT && from_owner) map_mem[addr_q] <= new_leaf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lfsr        <= SEED;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      blk_q       <= '0;
      new_leaf    <= '0;
      hit_q       <= 1'b0;
      map_vld     <= '0;
      probes      <= '0;
      gap_cnt     <= '0;
      ack         <= '0;
      probe_err   <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          new_leaf <= lfsr[LW-1:0];
          lfsr     <= lfsr_nxt;
          hit_q    <= map_vld[req_addr];
          probes   <= '0;
          st       <= S_ACC;
        end
        S_ACC: if (cmd_ready) st <= S_PRB;
        S_PRB: if (cmd_ready) begin
          probes <= probes + 1'b1;
          st     <= S_PWT;
        end
        S_PWT: if (from_owner) begin
          if (!mrsp_busy) st <= S_FET;
          else if (probes == CW'(PROBE_MAX)) begin
            probe_err <= 1'b1;
            st        <= S_IDLE;
          end else begin
            gap_cnt <= '0;
            st      <= S_GAP;
          end
        end
        S_GAP: if (gap_cnt == GW'(GAP - 1)) st <= S_PRB;
               else gap_cnt <= gap_cnt + 1'b1;
        S_FET: if (cmd_ready) st <= S_FWT;
        S_FWT: if (from_owner) begin
          blk_q           <= mrsp_data;
          map_vld[addr_q] <= 1'b1;
          st              <= S_APP;
        end
        S_APP: if (cmd_ready) begin
          ack <= '0;
          st  <= S_AWT;
        end
        S_AWT: if (mrsp_valid) begin
          if ((ack | src_bit) == 2'b11) begin
            st          <= S_IDLE;
            rsp_valid_q <= !wr_q;
          end else ack <= ack | src_bit;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oram_host_seq_chk.sv
module oram_host_seq_chk #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [1:0]    cmd_dest,
  input logic [AW-1:0] cmd_addr,
  input logic [LW-1:0] cmd_leaf,
  input logic [DW-1:0] cmd_data,
  input logic          probe_err
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);
  // R7
  append_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> cmd_dest == 2'b11);
  // R2
  unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd3) |-> $countones(cmd_dest) == 1);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_dest)
      && $stable(cmd_addr) && $stable(cmd_leaf) && $stable(cmd_data)));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_err |=> probe_err);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind oram_host_seq oram_host_seq_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_dest(cmd_dest),
  .cmd_addr(cmd_addr), .cmd_leaf(cmd_leaf), .cmd_data(cmd_data), .probe_err(probe_err)
);

// File: tb/tb_oram_host_seq.sv
module tb_oram_host_seq;
  localparam int AW = 4, DW = 32, LW = 8;
  localparam int NV = 9;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 4'h3, 32'h11111111, 8'd0, 1'b0},
    {1'b1, 4'h5, 32'h22222222, 8'd2, 1'b0},
    {1'b0, 4'h3, 32'h0,        8'd0, 1'b1},
    {1'b0, 4'h5, 32'h0,        8'd1, 1'b0},
    {1'b1, 4'h3, 32'h33333333, 8'd3, 1'b1},
    {1'b0, 4'h3, 32'h0,        8'd0, 1'b0},
    {1'b0, 4'h9, 32'h0,        8'd0, 1'b0},
    {1'b1, 4'hF, 32'hDEADBEEF, 8'd0, 1'b0},
    {1'b0, 4'hF, 32'h0,        8'd5, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, cmd_valid, cmd_write, probe_err;
  logic [AW-1:0] rsp_addr, cmd_addr;
  logic [DW-1:0] rsp_rdata, cmd_data;
  logic [1:0] cmd_op, cmd_dest;
  logic [LW-1:0] cmd_leaf;
  logic cmd_ready = 1, mrsp_valid = 0, mrsp_src = 0, mrsp_busy = 0;
  logic [DW-1:0] mrsp_data = '0;

  always #2 clk = ~clk;

  oram_host_seq dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [LW-1:0] ml [16];
  logic mv [16];
  logic [DW-1:0] mem_m [16], store [16];
  logic [15:0] mlfsr = 16'hACE1;
  logic [LW-1:0] exp_old, exp_new;
  logic [1:0] exp_mask;
  logic [DW-1:0] exp_data;
  int busy_left = 0, nprobe = 0, nfetch = 0, busy_at = 0;
  bit stall_mode = 0, last_busy = 0, was_stall = 0;
  logic [1:0] p_op, p_dest;
  logic [LW-1:0] p_leaf;
  logic [DW-1:0] p_data;
  logic q_src [4], q_busy [4];
  logic [DW-1:0] q_data [4];
  int qn = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic push(input logic s, input logic b, input logic [DW-1:0] d);
    q_src[qn] = s; q_busy[qn] = b; q_data[qn] = d; qn++;
  endtask

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (!rst_n) begin
      qn = 0; mrsp_valid = 0; was_stall = 0; cmd_ready = 1;
    end else begin
      if (was_stall)
        chk(cmd_valid && cmd_op == p_op && cmd_dest == p_dest && cmd_leaf == p_leaf
            && cmd_data == p_data, "R11 stalled command held", {cmd_op, cmd_leaf}, {p_op, p_leaf});
      if (qn > 0) begin
        mrsp_valid = 1; mrsp_src = q_src[0]; mrsp_busy = q_busy[0]; mrsp_data = q_data[0];
        for (int k = 0; k < 3; k++) begin
          q_src[k] = q_src[k+1]; q_busy[k] = q_busy[k+1]; q_data[k] = q_data[k+1];
        end
        qn--;
        if (mrsp_busy) begin busy_at = cyc; last_busy = 1; end
      end else mrsp_valid = 0;
      rdy = stall_mode ? (cyc % 3 != 0) : 1'b1;
      cmd_ready = rdy;
      was_stall = cmd_valid && !rdy;
      p_op = cmd_op; p_dest = cmd_dest; p_leaf = cmd_leaf; p_data = cmd_data;
      if (cmd_valid && rdy) begin
        case (cmd_op)
          2'd0: begin
            chk(cmd_dest == exp_mask, "R2 access dest", cmd_dest, exp_mask);
            chk(cmd_leaf == exp_old, "R10 access uses mapped leaf", cmd_leaf, exp_old);
            chk(!req_ready, "R8 ready low at access", req_ready, 0);
            if (cmd_write) begin
              chk(cmd_data == exp_data, "R2 write data", cmd_data, exp_data);
              store[cmd_addr] = cmd_data;
            end
          end
          2'd1: begin
            nprobe++;
            chk(cmd_dest == exp_mask, "R3 probe dest", cmd_dest, exp_mask);
            if (last_busy && !stall_mode)
              chk(cyc - busy_at == 5, "R3 reprobe gap", cyc - busy_at, 5);
            last_busy = 0;
            push(exp_mask[1], busy_left > 0, '0);
            if (busy_left > 0) busy_left--;
          end
          2'd2: begin
            nfetch++;
            chk(cmd_dest == exp_mask, "R5 fetch dest", cmd_dest, exp_mask);
            push(exp_mask[1], 1'b0, store[cmd_addr]);
          end
          default: begin
            chk(cmd_dest == 2'b11, "R7 append broadcast", cmd_dest, 3);
            chk(cmd_leaf == exp_new, "R6 new leaf", cmd_leaf, exp_new);
            chk(cmd_data == exp_data, "R7 append data", cmd_data, exp_data);
            chk(!req_ready, "R8 ready low at append", req_ready, 0);
            push(1'b1, 1'b0, '0);
            push(1'b0, 1'b0, '0);
          end
        endcase
      end
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input bit stall, input bit expect_err);
    int n = 0;
    exp_old = mv[a] ? ml[a] : '0;
    exp_mask = exp_old[LW-1] ? 2'b10 : 2'b01;
    exp_new = mlfsr[LW-1:0];
    mlfsr = step(mlfsr);
    exp_data = wr ? d : mem_m[a];
    busy_left = busy; stall_mode = stall; nprobe = 0; nfetch = 0; last_busy = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 ready drops after accept", req_ready, 0);
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    if (expect_err) begin
      chk(probe_err == 1, "R4 timeout flag", probe_err, 1);
      chk(nprobe == 64, "R4 probe count", nprobe, 64);
      chk(nfetch == 0, "R4 no fetch", nfetch, 0);
      chk(!rsp_valid, "R4 no response", rsp_valid, 0);
    end else begin
      chk(nprobe == busy + 1, "R3 probe count", nprobe, busy + 1);
      chk(nfetch == 1, "R5 single fetch", nfetch, 1);
      if (wr) chk(!rsp_valid, "R9 no response on write", rsp_valid, 0);
      else begin
        chk(rsp_valid, "R9 read response", rsp_valid, 1);
        chk(rsp_addr == a, "R9 response addr", rsp_addr, a);
        chk(rsp_rdata == exp_data, "R9 response data", rsp_rdata, exp_data);
      end
      ml[a] = exp_new; mv[a] = 1;
      if (wr) mem_m[a] = d;
    end
    stall_mode = 0;
    @(negedge clk);
    chk(!rsp_valid, "R9 response one cycle", rsp_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mv[i] = 0; ml[i] = '0; mem_m[i] = '0; store[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !rsp_valid && !probe_err, "R1 reset state",
        {req_ready, cmd_valid, rsp_valid, probe_err}, 4'b1000);
    rst_n = 1;
    for (int v = 0; v < NV; v++)
      do_req(VEC[v][45], VEC[v][44:41], VEC[v][40:9], int'(VEC[v][8:1]), VEC[v][0], 0);
    do_req(0, 4'h5, '0, 1000, 0, 1);
    busy_left = 0;
    do_req(0, 4'h5, '0, 0, 0, 0);
    chk(probe_err == 1, "R4 flag sticky", probe_err, 1);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !rsp_valid && !probe_err, "R1 state after reset",
        {req_ready, cmd_valid, rsp_valid, probe_err}, 4'b1000);
    mlfsr = 16'hACE1;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    @(negedge clk);
    rst_n = 1;
    do_req(0, 4'h3, '0, 1, 0, 0);
    do_req(0, 4'h3, '0, 0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule